// File: doc/BRIEF.md
# Oversampled Asynchronous Serial Receiver

This block turns a raw asynchronous serial line into parallel bytes. A character on the line is one low start bit, eight data bits with the least significant bit first, and one high stop bit. There is no parity bit. The receiver runs from one clock at sixteen times the bit rate. It never derives a slower clock. Instead, a counter inside each bit period raises a single-cycle sample enable near the middle of the bit.

The line first passes through a two-flop synchronizer. A falling edge seen across the two stages, while no character is in progress, starts a new reception and sets the sampling phase. Each data bit and the stop bit are shifted into a nine-bit register. The start bit is never shifted in. When the stop bit has been sampled, the byte and a framing-error flag load together and a valid strobe pulses for one cycle. All counters then return to zero, so the next start edge can arrive directly after the stop bit and the sampling point is set again for every character.

Top module: `uart_rx_os`

## Requirements
- R1: The byte on `rx_data` is the eight bits that follow the start bit, the first of them in bit 0. The start bit never appears in the byte.
- R2: Count as edge 0 the first rising clock edge at which `rx_line` is registered low after idle. The received character is then presented in the cycle after edge 153, which is 9 + 16·9.
- R3: A new character is recognised only while no reception is in progress. Falling edges on the line inside a frame do not restart reception.
- R4: Each bit is taken from the line value registered at offset 7 of its 16-cycle bit period. Line values outside that point in the bit do not affect the result.
- R5: `rx_valid` is high for exactly one cycle per character. `rx_data` and `rx_frame_err` change only in that cycle and hold their values between characters.
- R6: `rx_frame_err` is 1 when the sampled stop bit is 0 and 0 when it is 1. The byte is delivered in both cases, and the next good frame clears the flag.
- R7: A start bit that follows the stop bit with no idle time, or after any idle gap, is received correctly. The sampling phase is set again from each start edge.
- R8: Reset clears `rx_data`, `rx_frame_err` and `rx_valid` to 0 and abandons any frame in progress. After reset the receiver waits idle for the next falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at 16 times the bit rate |
| rst | input | 1 | Synchronous reset, active high |
| rx_line | input | 1 | Raw asynchronous serial line, idle high |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle strobe when a character completes |
| rx_frame_err | output | 1 | Stop bit of the last character was low |

## Verification
Isolated frames with an idle gap give the basic byte and latency check. A byte of alternating bits puts falling edges inside the frame, which catches any restart of reception during a frame. Back-to-back frames and frames separated by odd gaps of 3, 5 and 11 cycles show whether the phase is set again on each start edge or drifts. Frames whose data bits are correct only at offsets 4 to 11 of each bit period, and inverted elsewhere, confirm the mid-bit sampling point. A frame with a low stop bit and a reset in the middle of a frame cover the framing flag and the abandon-and-rearm behaviour.

// File: rtl/uart_rx_os_pkg.sv
`timescale 1ns/1ps
package uart_rx_os_pkg;

  // Index of the last sample in a frame: start (0), data (1..N), stop (N+1).
  function automatic int unsigned last_sample_idx(input int unsigned data_bits);
    return data_bits + 1;
  endfunction

  // Width of a counter holding 0..maxv.
  function automatic int unsigned cnt_width(input int unsigned maxv);
    return (maxv < 2) ? 1 : $clog2(maxv + 1);
  endfunction

  // Next oversampling phase, wrapping at the bit period.
  function automatic int unsigned next_phase(input int unsigned ph, input int unsigned period);
    return (ph == period - 1) ? 0 : ph + 1;
  endfunction

endpackage

// File: rtl/uart_rx_sync.sv
`timescale 1ns/1ps
module uart_rx_sync (
  input  logic clk,
  input  logic rst,
  input  logic line_i,
  output logic stage1_o,
  output logic stage2_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      stage1_o <= 1'b1;
      stage2_o <= 1'b1;
    end else begin
      stage1_o <= line_i;
      stage2_o <= stage1_o;
    end
  end
endmodule

// File: rtl/uart_rx_timing.sv
`timescale 1ns/1ps
module uart_rx_timing
  import uart_rx_os_pkg::*;
#(
  parameter int unsigned OVERSAMPLE   = 16,
  parameter int unsigned SAMPLE_POINT = 7,
  parameter int unsigned DATA_BITS    = 8,
  localparam int unsigned PHW  = cnt_width(OVERSAMPLE - 1),
  localparam int unsigned IDXW = cnt_width(last_sample_idx(DATA_BITS))
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            stage1_i,
  input  logic            stage2_i,
  output logic            start_det_o,
  output logic            busy_o,
  output logic            sample_en_o,
  output logic            frame_end_o,
  output logic [IDXW-1:0] bit_idx_o
);
  localparam logic [PHW-1:0]  SAMPLE_PH = PHW'(SAMPLE_POINT);
  localparam logic [IDXW-1:0] LAST_IDX  = IDXW'(last_sample_idx(DATA_BITS));

  logic [PHW-1:0] phase;

  assign start_det_o = !stage1_i && stage2_i && !busy_o;
  assign sample_en_o = busy_o && (phase == SAMPLE_PH);
  assign frame_end_o = sample_en_o && (bit_idx_o == LAST_IDX);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_o    <= 1'b0;
      phase     <= '0;
      bit_idx_o <= '0;
    end else if (start_det_o) begin
      busy_o    <= 1'b1;
      phase     <= '0;
      bit_idx_o <= '0;
    end else if (busy_o) begin
      if (frame_end_o) begin
        busy_o    <= 1'b0;
        phase     <= '0;
        bit_idx_o <= '0;
      end else begin
        phase <= PHW'(next_phase(int'(phase), OVERSAMPLE));
        if (sample_en_o) bit_idx_o <= bit_idx_o + 1'b1;
      end
    end
  end
endmodule

// File: rtl/uart_rx_shift.sv
`timescale 1ns/1ps
module uart_rx_shift #(
  parameter int unsigned DATA_BITS = 8,
  parameter int unsigned IDXW      = 4,
  localparam int unsigned FW = DATA_BITS + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bit_i,
  input  logic                 sample_en_i,
  input  logic                 frame_end_i,
  input  logic [IDXW-1:0]      bit_idx_i,
  output logic [DATA_BITS-1:0] data_o,
  output logic                 ferr_o,
  output logic                 valid_o
);
  logic [FW-1:0] frame_q;
  logic [FW-1:0] frame_nxt;

  // Sample 0 is the start bit: it is never shifted in.
  assign frame_nxt = {bit_i, frame_q[FW-1:1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      frame_q <= '0;
      data_o  <= '0;
      ferr_o  <= 1'b0;
      valid_o <= 1'b0;
    end else begin
      if (sample_en_i && (bit_idx_i != '0)) frame_q <= frame_nxt;
      valid_o <= frame_end_i;
      if (frame_end_i) begin
        data_o <= frame_nxt[DATA_BITS-1:0];
        ferr_o <= !frame_nxt[FW-1];
      end
    end
  end
endmodule

// File: rtl/uart_rx_os.sv
`timescale 1ns/1ps
module uart_rx_os
  import uart_rx_os_pkg::*;
#(
  parameter int unsigned OVERSAMPLE   = 16,
  parameter int unsigned SAMPLE_POINT = 7,
  parameter int unsigned DATA_BITS    = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rx_line,
  output logic [DATA_BITS-1:0] rx_data,
  output logic                 rx_valid,
  output logic                 rx_frame_err
);
  localparam int unsigned IDXW = cnt_width(last_sample_idx(DATA_BITS));

  logic            sync1, sync2;
  logic            start_det, busy, sample_en, frame_end;
  logic [IDXW-1:0] bit_idx;

  uart_rx_sync u_sync (
    .clk(clk), .rst(rst), .line_i(rx_line),
    .stage1_o(sync1), .stage2_o(sync2)
  );

  uart_rx_timing #(
    .OVERSAMPLE(OVERSAMPLE), .SAMPLE_POINT(SAMPLE_POINT), .DATA_BITS(DATA_BITS)
  ) u_timing (
    .clk(clk), .rst(rst), .stage1_i(sync1), .stage2_i(sync2),
    .start_det_o(start_det), .busy_o(busy), .sample_en_o(sample_en),
    .frame_end_o(frame_end), .bit_idx_o(bit_idx)
  );

  uart_rx_shift #(.DATA_BITS(DATA_BITS), .IDXW(IDXW)) u_shift (
    .clk(clk), .rst(rst), .bit_i(sync2), .sample_en_i(sample_en),
    .frame_end_i(frame_end), .bit_idx_i(bit_idx),
    .data_o(rx_data), .ferr_o(rx_frame_err), .valid_o(rx_valid)
  );
endmodule

// File: rtl/uart_rx_os_chk.sv
`timescale 1ns/1ps
module uart_rx_os_chk #(
  parameter int unsigned DATA_BITS = 8,
  parameter int unsigned IDXW      = 4
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 start_det,
  input logic                 busy,
  input logic                 sample_en,
  input logic                 frame_end,
  input logic [IDXW-1:0]      bit_idx,
  input logic                 valid,
  input logic                 ferr,
  input logic [DATA_BITS-1:0] data
);
  // R3: a recognised start edge arms reception at the first sample index
  p_start_arms_r3: assert property (@(posedge clk) disable iff (rst)
    start_det |=> (busy && bit_idx == '0));

  // R4: sample enables are isolated single-cycle pulses
  p_sample_single_r4: assert property (@(posedge clk) disable iff (rst)
    sample_en |=> !sample_en);

  // R5: strobe lasts one cycle
  p_valid_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    valid |=> !valid);

  // R5: strobe follows the end of a frame
  p_valid_follows_end_r5: assert property (@(posedge clk) disable iff (rst)
    frame_end |=> valid);

  // R5: outputs hold between characters
  p_outputs_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !valid |-> ($stable(data) && $stable(ferr)));

  // R7: receiver is idle after each frame, ready for the next start edge
  p_idle_after_end_r7: assert property (@(posedge clk) disable iff (rst)
    frame_end |=> !busy);
endmodule

bind uart_rx_os uart_rx_os_chk #(.DATA_BITS(DATA_BITS), .IDXW(IDXW)) u_chk (
  .clk(clk), .rst(rst), .start_det(start_det), .busy(busy),
  .sample_en(sample_en), .frame_end(frame_end), .bit_idx(bit_idx),
  .valid(rx_valid), .ferr(rx_frame_err), .data(rx_data)
);

// File: tb/tb_uart_rx_os.sv
`timescale 1ns/1ps
module tb_uart_rx_os;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rxd = 1'b1;
  logic [7:0] rx_data;
  logic       rx_valid, rx_frame_err;

  always #2.5 clk = ~clk;

  uart_rx_os dut (
    .clk(clk), .rst(rst), .rx_line(rxd),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_frame_err(rx_frame_err)
  );

  typedef struct {
    int         due;
    logic [7:0] byte_v;
    logic       fe;
    string      tag;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   n_chk = 0;
  int   n_err = 0;
  bit   mon_on = 1'b0;
  bit   done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h (cycle %0d)", tag, what, act, expv, cyc);
    end
  endtask

  // Reference model: every clock, the strobe must match the predicted due cycle.
  always @(negedge clk) begin
    if (mon_on && !rst) begin
      if (q.size() > 0 && q[0].due == cyc) begin
        chk(rx_valid == 1'b1, "R2", "valid strobe", int'(rx_valid), 1);
        chk(rx_data == q[0].byte_v, q[0].tag, "data byte (R1)", int'(rx_data), int'(q[0].byte_v));
        chk(rx_frame_err == q[0].fe, q[0].tag, "framing flag (R6)", int'(rx_frame_err), int'(q[0].fe));
        void'(q.pop_front());
      end else begin
        chk(rx_valid == 1'b0, "R5", "idle strobe", int'(rx_valid), 0);
      end
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rxd = 1'b1;
    end
  endtask

  // skew: data bits are correct only at offsets 4..11 of each bit period.
  task automatic send(input logic [7:0] b, input logic stop_v, input bit skew, input string tag);
    logic v;
    exp_t e;
    for (int k = 0; k < 10; k++) begin
      for (int j = 0; j < 16; j++) begin
        @(negedge clk);
        if (k == 0 && j == 0) begin
          e.due = cyc + 154; e.byte_v = b; e.fe = !stop_v; e.tag = tag;
          q.push_back(e);
        end
        if (k == 0) v = 1'b0;
        else if (k == 9) v = stop_v;
        else v = b[k-1];
        if (skew && k >= 1 && k <= 8 && (j < 4 || j > 11)) v = !v;
        rxd = v;
      end
    end
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(rx_data == 8'h00, "R8", "data after reset", int'(rx_data), 0);
    chk(rx_valid == 1'b0, "R8", "valid after reset", int'(rx_valid), 0);
    chk(rx_frame_err == 1'b0, "R8", "flag after reset", int'(rx_frame_err), 0);
    mon_on = 1'b1;
    idle(20);
    send(8'hA5, 1'b1, 1'b0, "R1");  idle(7);
    send(8'h55, 1'b1, 1'b0, "R3");  idle(3);
    // back to back, no idle between stop and next start
    send(8'h00, 1'b1, 1'b0, "R7");
    send(8'hFF, 1'b1, 1'b0, "R7");
    send(8'h3C, 1'b1, 1'b0, "R7");  idle(16);
    send(8'h81, 1'b1, 1'b0, "R7");  idle(5);
    send(8'h7E, 1'b1, 1'b0, "R7");  idle(11);
    // mid-bit sampling with corrupted bit edges
    send(8'hC3, 1'b1, 1'b1, "R4");  idle(9);
    send(8'h1E, 1'b1, 1'b1, "R4");
    send(8'h96, 1'b1, 1'b1, "R4");  idle(20);
    // bad stop bit, then good frame clears the flag
    send(8'h5A, 1'b0, 1'b0, "R6");  idle(20);
    send(8'h99, 1'b1, 1'b0, "R6");  idle(20);
    send(8'h80, 1'b0, 1'b0, "R6");  idle(20);
    // reset in the middle of a frame
    for (int i = 0; i < 16; i++) begin @(negedge clk); rxd = 1'b0; end
    for (int i = 0; i < 40; i++) begin @(negedge clk); rxd = (i % 3 == 0); end
    @(negedge clk);
    rxd = 1'b1;
    rst = 1'b1;
    q.delete();
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(rx_data == 8'h00, "R8", "data after mid-frame reset", int'(rx_data), 0);
    chk(rx_frame_err == 1'b0, "R8", "flag after mid-frame reset", int'(rx_frame_err), 0);
    chk(rx_valid == 1'b0, "R8", "valid after mid-frame reset", int'(rx_valid), 0);
    idle(300);
    send(8'h6B, 1'b1, 1'b0, "R8");  idle(200);
    chk(q.size() == 0, "R2", "pending characters", q.size(), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule